// File: doc/BRIEF.md
# Masked Edge and Level Interrupt Aggregator

This block gathers a set of raw interrupt request lines, by default 24 of them, into byte-wide banks and presents one combined interrupt line to a host processor. Every raw line is first brought into the block clock domain through a short synchronizer chain. All lines but one are treated as edge requests: a rising edge on the synchronized line sets a sticky status bit, provided the bank's enable (mask) bit for that line is 1 at that moment. Software reads a bank's status byte to learn which sources fired, and that same read clears the edge bits it returned. No acknowledge write exists. One line, chosen by a parameter, is a level request whose status bit simply mirrors the synchronized input.

The pending vector is status AND enable, with bank 0 in bits 7:0, bank 1 in bits 15:8 and bank 2 in bits 23:16. A two-state machine drives the combined line. In state OUT_IDLE the line is low, and the transition GO_RAISE (any pending bit set) moves it to OUT_RAISED. In OUT_RAISED the line is high, and the transition GO_IDLE (no pending bit set) returns it to OUT_IDLE. Both states hold while their exit condition is false. The host sees a new rising edge only after every pending bit has cleared and a fresh one has set. Because an edge is dropped when it arrives while its source is disabled, software has to enable a source before the event it wants to catch.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, irq_o is 0, every enable byte reads 0x00 and every status byte reads 0x00 while all raw inputs are low.
- R2: The register map uses byte offsets. Offsets 0, 1 and 2 read status banks 0, 1 and 2. Offsets 4, 5 and 6 read and write enable banks 0, 1 and 2. Writes to offsets 0 to 2 are ignored. Offsets 3 and 7 read as 0x00 and ignore writes. Read data appears on bus_rdata_o one clock after the edge at which bus_rd_i is sampled high.
- R3: A rising edge on an edge-type input sets its status bit only if its enable bit is 1 when the synchronized edge is seen. An edge seen while the enable bit is 0 is lost, and setting the enable bit afterwards does not recover it.
- R4: Reading a status offset returns the bits held before the read and clears the edge-type bits of that bank. The level-type bit is not cleared.
- R5: If a synchronized edge on an enabled source falls in the same cycle as the read that would clear its bit, the bit stays set. The read returns the old value, and the next read returns 1 for that bit.
- R6: The level-type source (parameter LEVEL_IDX, default 2, so bit 2 of status bank 0) has a status bit that equals its synchronized input whatever the enable bit holds. It raises irq_o only while it is enabled.
- R7: irq_o is 1 exactly when some bit of status AND enable is set, using the bank-to-bit layout above. Disabling a latched bit drops irq_o but keeps the status bit, and enabling it again raises irq_o.
- R8: With the source enabled and idle, a raw edge-type input that rises before clock edge 1 makes irq_o go high after clock edge 4 and not earlier. Edges 1 and 2 are the synchronizer, edge 3 sets status, and edge 4 moves the output state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw_i | input | 24 | Raw interrupt request lines, bit n is source n |
| bus_addr_i | input | 3 | Register byte offset |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt line to the host |

## Verification
A status latch stuck at 1 shows up at once as irq_o staying high after the status bytes have been read. A second read of the same offset then returns a non-zero byte. A lost clear, or a clear that wins over a simultaneous edge, shows in the read that follows, one cycle after the strobe. A corrupted enable register shows up in its read-back, and also in irq_o four clock edges after the next edge on a source it covers. A wrong output state shows within one cycle as irq_o disagreeing with the status and enable values read through the bus.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

    typedef enum logic [0:0] {
        OUT_IDLE   = 1'b0,
        OUT_RAISED = 1'b1
    } out_state_t;

    localparam int OFS_BANK_BITS = 2;

endpackage

// File: rtl/irqa_sync_edge.sv
module irqa_sync_edge #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= '0;
        end else begin
            chain_q[0] <= raw_i;
        end
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else begin
                    chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else begin
            last_q <= chain_q[STAGES-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/irqa_bank.sv
module irqa_bank #(
    parameter int BANK_W  = 8,
    parameter int LVL_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] sync_i,
    input  logic [BANK_W-1:0] rise_i,
    input  logic [BANK_W-1:0] mask_i,
    input  logic              clr_i,
    output logic [BANK_W-1:0] status_o,
    output logic [BANK_W-1:0] pending_o
);

    genvar i;
    generate
        for (i = 0; i < BANK_W; i++) begin : g_bit
            if (i == LVL_POS) begin : g_level
                assign status_o[i] = sync_i[i];
            end else begin : g_edge
                logic hold_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        hold_q <= 1'b0;
                    end else if (rise_i[i] && mask_i[i]) begin
                        hold_q <= 1'b1;
                    end else if (clr_i) begin
                        hold_q <= 1'b0;
                    end
                end
                assign status_o[i] = hold_q;
            end
        end
    endgenerate

    assign pending_o = status_o & mask_i;

endmodule

// File: rtl/irqa_regs.sv
module irqa_regs #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BANK_W-1:0]           wdata_i,
    input  logic                        wr_i,
    input  logic                        rd_i,
    input  logic [NUM_BANKS*BANK_W-1:0] status_i,
    output logic [NUM_BANKS*BANK_W-1:0] mask_o,
    output logic [NUM_BANKS-1:0]        clr_o,
    output logic [BANK_W-1:0]           rdata_o
);

    localparam int SEL_W = ADDR_W - 1;

    logic [SEL_W-1:0]  sel;
    logic              is_mask;
    logic [BANK_W-1:0] rd_mux;

    assign sel     = addr_i[SEL_W-1:0];
    assign is_mask = addr_i[ADDR_W-1];

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mask_o[b*BANK_W +: BANK_W] <= '0;
                end else if (wr_i && is_mask && (sel == SEL_W'(b))) begin
                    mask_o[b*BANK_W +: BANK_W] <= wdata_i;
                end
            end
            assign clr_o[b] = rd_i && !is_mask && (sel == SEL_W'(b));
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (sel == SEL_W'(k)) begin
                rd_mux = is_mask ? mask_o[k*BANK_W +: BANK_W]
                                 : status_i[k*BANK_W +: BANK_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            rdata_o <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int NUM_BANKS   = 3,
    parameter int BANK_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int LEVEL_IDX   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_raw_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic [BANK_W-1:0]           bus_wdata_i,
    input  logic                        bus_wr_i,
    input  logic                        bus_rd_i,
    output logic [BANK_W-1:0]           bus_rdata_o,
    output logic                        irq_o
);

    import irqa_pkg::*;

    localparam int N = NUM_BANKS * BANK_W;

    logic [N-1:0]         sync_vec;
    logic [N-1:0]         rise_vec;
    logic [N-1:0]         status_vec;
    logic [N-1:0]         mask_vec;
    logic [N-1:0]         pending_vec;
    logic [NUM_BANKS-1:0] clr_vec;
    logic                 any_pending;

    out_state_t state_q, state_d;

    irqa_sync_edge #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (irq_raw_i),
        .sync_o (sync_vec),
        .rise_o (rise_vec)
    );

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam int LVL = (LEVEL_IDX / BANK_W == b) ? (LEVEL_IDX % BANK_W) : BANK_W;
            irqa_bank #(.BANK_W(BANK_W), .LVL_POS(LVL)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .sync_i    (sync_vec[b*BANK_W +: BANK_W]),
                .rise_i    (rise_vec[b*BANK_W +: BANK_W]),
                .mask_i    (mask_vec[b*BANK_W +: BANK_W]),
                .clr_i     (clr_vec[b]),
                .status_o  (status_vec[b*BANK_W +: BANK_W]),
                .pending_o (pending_vec[b*BANK_W +: BANK_W])
            );
        end
    endgenerate

    irqa_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .wr_i     (bus_wr_i),
        .rd_i     (bus_rd_i),
        .status_i (status_vec),
        .mask_o   (mask_vec),
        .clr_o    (clr_vec),
        .rdata_o  (bus_rdata_o)
    );

    assign any_pending = |pending_vec;

    // State register of the output machine.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: GO_RAISE and GO_IDLE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE:   if (any_pending)  state_d = OUT_RAISED;
            OUT_RAISED: if (!any_pending) state_d = OUT_IDLE;
            default:    state_d = OUT_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            OUT_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irqa_checker.sv
module irqa_checker #(
    parameter int N         = 24,
    parameter int ADDR_W    = 3,
    parameter int LEVEL_IDX = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      status_vec,
    input logic [N-1:0]      mask_vec,
    input logic [N-1:0]      rise_vec,
    input logic [N-1:0]      sync_vec,
    input logic [N-1:0]      pending_vec,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic              irq_o
);

    localparam logic [N-1:0] EDGE_BITS = ~(N'(1) << LEVEL_IDX);

    p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !irq_o);

    p_status_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !bus_addr_i[ADDR_W-1]) |=> $stable(mask_vec));

    p_masked_edge_lost_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_vec & ~$past(status_vec) & ~$past(mask_vec) & EDGE_BITS) == '0));

    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == '0 && rise_vec[7:0] == 8'h00)
        |=> ((status_vec[7:0] & EDGE_BITS[7:0]) == 8'h00));

    p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_vec & mask_vec) != '0)
        |=> ((status_vec & $past(rise_vec & mask_vec)) == $past(rise_vec & mask_vec)));

    p_level_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_vec[LEVEL_IDX] == sync_vec[LEVEL_IDX]);

    p_irq_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(pending_vec != '0)));

endmodule

bind irq_aggregator irqa_checker #(
    .N         (NUM_BANKS * BANK_W),
    .ADDR_W    (ADDR_W),
    .LEVEL_IDX (LEVEL_IDX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_vec  (status_vec),
    .mask_vec    (mask_vec),
    .rise_vec    (rise_vec),
    .sync_vec    (sync_vec),
    .pending_vec (pending_vec),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .irq_o       (irq_o)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] raw = '0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  rdata;
    logic        irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    irq_aggregator u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_raw_i   (raw),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // {enable mask, raw pulse, expected status}
    localparam logic [71:0] VEC [6] = '{
        {24'hFFFFFF, 24'h000001, 24'h000001},
        {24'h000000, 24'h0000F0, 24'h000000},
        {24'h00FF00, 24'h01FF10, 24'h00FF00},
        {24'hF0F0F0, 24'hFFFFFB, 24'hF0F0F0},
        {24'h800000, 24'h800000, 24'h800000},
        {24'hFFFFFF, 24'hA5A5A1, 24'hA5A5A1}
    };

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [23:0] p);
        raw = p; cyc(3);
        raw = '0; cyc(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R1: reset state
        check("R1 irq after reset", {23'd0, irq}, 24'd0);
        for (int k = 0; k < 3; k++) begin
            rd_reg(3'(4 + k), d); check("R1 enable reset", {16'd0, d}, 24'd0);
            rd_reg(3'(k), d);     check("R1 status reset", {16'd0, d}, 24'd0);
        end

        // R2: map, read-back, ignored writes, unmapped offsets
        wr_reg(3'd5, 8'h5A);
        rd_reg(3'd5, d); check("R2 enable readback", {16'd0, d}, 24'h00005A);
        wr_reg(3'd0, 8'hFF);
        rd_reg(3'd0, d); check("R2 status write ignored", {16'd0, d}, 24'd0);
        wr_reg(3'd3, 8'hFF);
        wr_reg(3'd7, 8'hFF);
        rd_reg(3'd3, d); check("R2 unmapped 3", {16'd0, d}, 24'd0);
        rd_reg(3'd7, d); check("R2 unmapped 7", {16'd0, d}, 24'd0);
        rd_reg(3'd4, d); check("R2 enable 0 untouched", {16'd0, d}, 24'd0);
        rd_reg(3'd6, d); check("R2 enable 2 untouched", {16'd0, d}, 24'd0);
        wr_reg(3'd5, 8'h00);

        // Table walk: R3 R4 R7
        foreach (VEC[i]) begin
            logic [23:0] m, p, e, got;
            {m, p, e} = VEC[i];
            wr_reg(3'd4, m[7:0]); wr_reg(3'd5, m[15:8]); wr_reg(3'd6, m[23:16]);
            cyc(2);
            pulse(p);
            check("R7 irq for vector", {23'd0, irq}, {23'd0, (e != 0)});
            rd_reg(3'd0, got[7:0]); rd_reg(3'd1, got[15:8]); rd_reg(3'd2, got[23:16]);
            check("R3 status for vector", got, e);
            rd_reg(3'd0, got[7:0]); rd_reg(3'd1, got[15:8]); rd_reg(3'd2, got[23:16]);
            check("R4 status cleared by read", got, 24'd0);
            cyc(2);
            check("R7 irq after clear", {23'd0, irq}, 24'd0);
        end

        // R3: edge lost while disabled, not recovered by enabling
        wr_reg(3'd4, 8'h00); wr_reg(3'd5, 8'h00); wr_reg(3'd6, 8'h00);
        pulse(24'h000010);
        wr_reg(3'd4, 8'h10); cyc(3);
        check("R3 masked edge irq", {23'd0, irq}, 24'd0);
        rd_reg(3'd0, d); check("R3 masked edge status", {16'd0, d}, 24'd0);
        wr_reg(3'd4, 8'h00);

        // R6: level source
        raw[2] = 1'b1; cyc(4);
        rd_reg(3'd0, d); check("R6 level visible while disabled", {16'd0, d}, 24'h000004);
        check("R6 level disabled no irq", {23'd0, irq}, 24'd0);
        wr_reg(3'd4, 8'h04); cyc(2);
        check("R6 level enabled irq", {23'd0, irq}, 24'd1);
        rd_reg(3'd0, d); check("R6 level survives read", {16'd0, d}, 24'h000004);
        raw[2] = 1'b0; cyc(4);
        rd_reg(3'd0, d); check("R6 level follows low", {16'd0, d}, 24'd0);
        check("R6 irq drops with level", {23'd0, irq}, 24'd0);
        wr_reg(3'd4, 8'h00);

        // R8: latency
        wr_reg(3'd5, 8'h02); cyc(2);
        raw[9] = 1'b1;
        cyc(3);
        check("R8 irq not before edge 4", {23'd0, irq}, 24'd0);
        cyc(1);
        check("R8 irq at edge 4", {23'd0, irq}, 24'd1);
        raw[9] = 1'b0; cyc(3);
        rd_reg(3'd1, d); check("R8 status bank 1", {16'd0, d}, 24'h000002);
        wr_reg(3'd5, 8'h00);

        // R7: disable latched bit, then enable again
        wr_reg(3'd4, 8'h01); cyc(2);
        pulse(24'h000001);
        wr_reg(3'd4, 8'h00); cyc(1);
        check("R7 disable drops irq", {23'd0, irq}, 24'd0);
        wr_reg(3'd4, 8'h01); cyc(1);
        check("R7 enable restores irq", {23'd0, irq}, 24'd1);
        rd_reg(3'd0, d); check("R7 status kept while disabled", {16'd0, d}, 24'h000001);

        // R5: edge in the same cycle as the clearing read
        pulse(24'h000001);
        raw[0] = 1'b1;
        cyc(2);
        rd_reg(3'd0, d); check("R5 read returns old value", {16'd0, d}, 24'h000001);
        rd_reg(3'd0, d); check("R5 edge wins over clear", {16'd0, d}, 24'h000001);
        rd_reg(3'd0, d); check("R5 next read clears", {16'd0, d}, 24'd0);
        raw[0] = 1'b0;
        cyc(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule